// File: doc/BRIEF.md
# PLL Bypass and Lock Sequencer

This block drives the control fields of a fractional PLL: power, bypass select, output gate, integer divider, fractional numerator and fractional denominator. It sequences them so that the clock seen downstream never comes from the PLL while the PLL is still acquiring lock. Three single-cycle requests are accepted: bring up the PLL, shut it down, and change its rate. A rate change carries a new divider and numerator.

The lock indication from the analog macro is treated as asynchronous and is resynchronised before use. Every wait for lock is bounded by a cycle-count timeout. If bring-up times out, the block returns the control fields to their values from before the request. If a rate change fails to relock, the block leaves the output on the bypass path. A rate change whose divider lies outside the legal multiplier window is refused outright and changes nothing. Each sequence finishes with a one-cycle `done` or `error` pulse.

Top module: `pll_seq`

## Requirements
- R1: Out of reset, `pll_bypass` is 1, `pll_out_en` is 0, `pll_power` is at its powered-down level, and `busy`, `done` and `error` are 0.
- R2: A bring-up request first sets power on and holds bypass at 1 until the synchronised lock has been seen. It then clears bypass, and on the following cycle sets `pll_out_en` and pulses `done`. Bypass never clears while lock is low.
- R3: If lock is not seen within `TIMEOUT_CYCLES` of a bring-up wait, power, bypass and output gate return to their values from before the request, and `error` pulses.
- R4: With `POWER_ON_LEVEL`=1, a powered PLL has `pll_power`=1. With `POWER_ON_LEVEL`=0, a powered PLL has `pll_power`=0.
- R5: A shutdown request sets bypass to 1 and clears `pll_out_en`, and removes power one cycle later. Power is never removed while bypass is 0.
- R6: A rate change sets bypass to 1 first. It then writes `pll_div`, `pll_num` and `pll_den` in three successive cycles, in that order. `pll_den` is always written as `DEN_VALUE` (default 1,000,000).
- R7: A rate change that arrives while the PLL is powered down skips the lock wait, pulses `done` right after the denominator write, and leaves bypass at 1.
- R8: After a rate change relocks, bypass returns to its value from before the request. If relock times out, bypass stays at 1 and `error` pulses.
- R9: A rate change whose `req_div` is below `MUL_MIN` (27) or above `MUL_MAX` (54) pulses `error` in the next cycle. No control field changes and `busy` stays 0.
- R10: Requests that arrive while `busy` is 1 are ignored.
- R11: `done` and `error` are each high for exactly one cycle and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_enable | input | 1 | Bring-up request pulse |
| req_disable | input | 1 | Shutdown request pulse |
| req_reprog | input | 1 | Rate change request pulse |
| req_div | input | DIV_W | Requested integer divider |
| req_num | input | NUM_W | Requested fractional numerator |
| lock_async | input | 1 | Lock indication from the PLL, asynchronous |
| pll_power | output | 1 | Power control bit, polarity set by POWER_ON_LEVEL |
| pll_bypass | output | 1 | 1 selects the reference clock path |
| pll_out_en | output | 1 | Output gate enable |
| pll_div | output | DIV_W | Integer divider field |
| pll_num | output | NUM_W | Fractional numerator field |
| pll_den | output | DEN_W | Fractional denominator field |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure or rejection pulse |

## Verification
The assertions assume that lock from the PLL falls as soon as the divider or numerator changes or power is removed, and that it rises only after the PLL has been stable for some delay. They also assume that requests are single-cycle pulses. The testbench meets both assumptions with a behavioural PLL model. The model drops lock on any change of the powered state or of the frequency fields, and raises it after a delay that the bench sets per test. The bench drives each request for exactly one cycle. To force timeouts, the bench sets the model delay longer than the timeout window.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UP_WAIT,
        ST_UP_GATE,
        ST_DN_PWR,
        ST_RP_DIV,
        ST_RP_NUM,
        ST_RP_DEN,
        ST_RP_WAIT
    } seq_state_e;

endpackage

// File: rtl/pll_seq_sync.sv
module pll_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b0;
                end else if (g == 0) begin
                    chain_q[g] <= din;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int LIMIT  = 20_000_000,
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired,
    output logic settled
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_V   = CW'(LIMIT - 1);
    localparam logic [CW-1:0] SETTLE_V = CW'(SETTLE);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q < LAST_V) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q >= LAST_V);
    assign settled = run && (cnt_q >= SETTLE_V);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_V); // R3
    AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> cnt_q == '0); // R3
endmodule

// File: rtl/pll_seq_range.sv
module pll_seq_range #(
    parameter int DIV_W   = 7,
    parameter int MUL_MIN = 27,
    parameter int MUL_MAX = 54
) (
    input  logic [DIV_W-1:0] div,
    output logic             legal
);
    localparam logic [DIV_W-1:0] LO_V = DIV_W'(MUL_MIN);
    localparam logic [DIV_W-1:0] HI_V = DIV_W'(MUL_MAX);

    always_comb begin
        legal = (div >= LO_V) && (div <= HI_V);
    end
endmodule

// File: rtl/pll_seq.sv
module pll_seq #(
    parameter int   DIV_W          = 7,
    parameter int   NUM_W          = 30,
    parameter int   DEN_W          = 30,
    parameter int   DEN_VALUE      = 1_000_000,
    parameter int   MUL_MIN        = 27,
    parameter int   MUL_MAX        = 54,
    parameter int   TIMEOUT_CYCLES = 20_000_000,
    parameter int   SETTLE_CYCLES  = 4,
    parameter int   SYNC_STAGES    = 2,
    parameter logic POWER_ON_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_enable,
    input  logic             req_disable,
    input  logic             req_reprog,
    input  logic [DIV_W-1:0] req_div,
    input  logic [NUM_W-1:0] req_num,
    input  logic             lock_async,
    output logic             pll_power,
    output logic             pll_bypass,
    output logic             pll_out_en,
    output logic [DIV_W-1:0] pll_div,
    output logic [NUM_W-1:0] pll_num,
    output logic [DEN_W-1:0] pll_den,
    output logic             busy,
    output logic             done,
    output logic             error
);
    import pll_seq_pkg::*;

    localparam logic             PWR_OFF   = ~POWER_ON_LEVEL;
    localparam logic [DEN_W-1:0] DEN_V     = DEN_W'(DEN_VALUE);
    localparam logic [DIV_W-1:0] DIV_RST_V = DIV_W'(MUL_MIN);

    typedef struct packed {
        seq_state_e       st;
        logic             power;
        logic             bypass;
        logic             out_en;
        logic [DIV_W-1:0] div;
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] den;
        logic             snap_power;
        logic             snap_bypass;
        logic             snap_out_en;
        logic [DIV_W-1:0] stg_div;
        logic [NUM_W-1:0] stg_num;
        logic             was_on;
        logic             busy;
        logic             done;
        logic             error;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic lock_s;
    logic wait_run;
    logic wait_expired;
    logic wait_settled;
    logic div_legal;
    logic pwr_on_q;

    pll_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lock_async),
        .dout (lock_s)
    );

    assign wait_run = (r_q.st == ST_UP_WAIT) || (r_q.st == ST_RP_WAIT);

    pll_seq_timer #(.LIMIT(TIMEOUT_CYCLES), .SETTLE(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wait_run),
        .expired(wait_expired),
        .settled(wait_settled)
    );

    pll_seq_range #(.DIV_W(DIV_W), .MUL_MIN(MUL_MIN), .MUL_MAX(MUL_MAX)) u_range (
        .div  (req_div),
        .legal(div_legal)
    );

    assign pwr_on_q = (r_q.power == POWER_ON_LEVEL);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.error = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.busy = 1'b0;
                if (req_enable) begin
                    r_d.snap_power  = r_q.power;
                    r_d.snap_bypass = r_q.bypass;
                    r_d.snap_out_en = r_q.out_en;
                    r_d.power       = POWER_ON_LEVEL;
                    r_d.busy        = 1'b1;
                    r_d.st          = ST_UP_WAIT;
                end else if (req_disable) begin
                    r_d.bypass = 1'b1;
                    r_d.out_en = 1'b0;
                    r_d.busy   = 1'b1;
                    r_d.st     = ST_DN_PWR;
                end else if (req_reprog) begin
                    if (!div_legal) begin
                        r_d.error = 1'b1;
                    end else begin
                        r_d.stg_div     = req_div;
                        r_d.stg_num     = req_num;
                        r_d.was_on      = pwr_on_q;
                        r_d.snap_bypass = r_q.bypass;
                        r_d.bypass      = 1'b1;
                        r_d.busy        = 1'b1;
                        r_d.st          = ST_RP_DIV;
                    end
                end
            end
            ST_UP_WAIT: begin
                if (lock_s && wait_settled) begin
                    r_d.bypass = 1'b0;
                    r_d.st     = ST_UP_GATE;
                end else if (wait_expired) begin
                    r_d.power  = r_q.snap_power;
                    r_d.bypass = r_q.snap_bypass;
                    r_d.out_en = r_q.snap_out_en;
                    r_d.error  = 1'b1;
                    r_d.busy   = 1'b0;
                    r_d.st     = ST_IDLE;
                end
            end
            ST_UP_GATE: begin
                r_d.out_en = 1'b1;
                r_d.done   = 1'b1;
                r_d.busy   = 1'b0;
                r_d.st     = ST_IDLE;
            end
            ST_DN_PWR: begin
                r_d.power = PWR_OFF;
                r_d.done  = 1'b1;
                r_d.busy  = 1'b0;
                r_d.st    = ST_IDLE;
            end
            ST_RP_DIV: begin
                r_d.div = r_q.stg_div;
                r_d.st  = ST_RP_NUM;
            end
            ST_RP_NUM: begin
                r_d.num = r_q.stg_num;
                r_d.st  = ST_RP_DEN;
            end
            ST_RP_DEN: begin
                r_d.den = DEN_V;
                if (r_q.was_on) begin
                    r_d.st = ST_RP_WAIT;
                end else begin
                    r_d.done = 1'b1;
                    r_d.busy = 1'b0;
                    r_d.st   = ST_IDLE;
                end
            end
            ST_RP_WAIT: begin
                if (lock_s && wait_settled) begin
                    r_d.bypass = r_q.snap_bypass;
                    r_d.done   = 1'b1;
                    r_d.busy   = 1'b0;
                    r_d.st     = ST_IDLE;
                end else if (wait_expired) begin
                    r_d.error = 1'b1;
                    r_d.busy  = 1'b0;
                    r_d.st    = ST_IDLE;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q             <= '0;
            r_q.st          <= ST_IDLE;
            r_q.power       <= PWR_OFF;
            r_q.bypass      <= 1'b1;
            r_q.snap_power  <= PWR_OFF;
            r_q.snap_bypass <= 1'b1;
            r_q.div         <= DIV_RST_V;
            r_q.stg_div     <= DIV_RST_V;
        end else begin
            r_q <= r_d;
        end
    end

    assign pll_power  = r_q.power;
    assign pll_bypass = r_q.bypass;
    assign pll_out_en = r_q.out_en;
    assign pll_div    = r_q.div;
    assign pll_num    = r_q.num;
    assign pll_den    = r_q.den;
    assign busy       = r_q.busy;
    assign done       = r_q.done;
    assign error      = r_q.error;

    AST_BYPASS_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_bypass) |-> $past(lock_async, 3)); // R2
    AST_GATE_ON_PLL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_out_en) |-> !pll_bypass && pwr_on_q); // R2
    AST_POWER_OFF_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_on_q) |-> $past(pll_bypass)); // R5
    AST_DEN_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_den) |-> pll_den == DEN_V); // R6
    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_div) |-> pll_div >= DIV_W'(MUL_MIN) && pll_div <= DIV_W'(MUL_MAX)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ERROR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error); // R11
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R11
    AST_FREQ_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) && !busy |-> $stable(pll_div) && $stable(pll_num)); // R10
endmodule

// File: tb/sim_pll_seq.sv
module sim_pll_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_on,
    input  logic [6:0]  div,
    input  logic [29:0] num,
    input  int          delay,
    output logic        lock
);
    logic [6:0]  div_prev;
    logic [29:0] num_prev;
    int          cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock     <= 1'b0;
            cnt      <= 0;
            div_prev <= '0;
            num_prev <= '0;
        end else begin
            div_prev <= div;
            num_prev <= num;
            if (!pwr_on || div != div_prev || num != num_prev) begin
                lock <= 1'b0;
                cnt  <= 0;
            end else if (cnt >= delay) begin
                lock <= 1'b1;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end
endmodule

module sim_pll_seq;
    localparam int TMO = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        en0 = 0, dis0 = 0, rp0 = 0;
    logic [6:0]  rdiv0 = 7'd40;
    logic [29:0] rnum0 = '0;
    logic        lock0;
    logic        pwr0, byp0, oe0, busy0, done0, err0;
    logic [6:0]  div0;
    logic [29:0] num0, den0;
    int          dly0 = 20;

    logic        en1 = 0;
    logic        lock1;
    logic        pwr1, byp1, oe1, busy1, done1, err1;
    logic [6:0]  div1;
    logic [29:0] num1, den1;

    pll_seq #(.TIMEOUT_CYCLES(TMO), .SETTLE_CYCLES(4), .POWER_ON_LEVEL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_enable(en0), .req_disable(dis0),
        .req_reprog(rp0), .req_div(rdiv0), .req_num(rnum0), .lock_async(lock0),
        .pll_power(pwr0), .pll_bypass(byp0), .pll_out_en(oe0), .pll_div(div0),
        .pll_num(num0), .pll_den(den0), .busy(busy0), .done(done0), .error(err0));

    pll_seq #(.TIMEOUT_CYCLES(TMO), .SETTLE_CYCLES(4), .POWER_ON_LEVEL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_enable(en1), .req_disable(1'b0),
        .req_reprog(1'b0), .req_div(7'd40), .req_num(30'd0), .lock_async(lock1),
        .pll_power(pwr1), .pll_bypass(byp1), .pll_out_en(oe1), .pll_div(div1),
        .pll_num(num1), .pll_den(den1), .busy(busy1), .done(done1), .error(err1));

    sim_pll_model m0 (.clk(clk), .rst_n(rst_n), .pwr_on(pwr0 == 1'b1), .div(div0),
                      .num(num0), .delay(dly0), .lock(lock0));
    sim_pll_model m1 (.clk(clk), .rst_n(rst_n), .pwr_on(pwr1 == 1'b0), .div(div1),
                      .num(num1), .delay(20), .lock(lock1));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit ended = 0;

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // waits for done or error on u0, then checks the one-cycle pulse (R11)
    task automatic wait_end0(output bit gd, output bit ge, output int n);
        gd = 0; ge = 0; n = 0;
        while (!done0 && !err0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        gd = done0; ge = err0;
        chk("R11 not both", !(done0 && err0), done0 && err0, 0);
        @(negedge clk);
        chk("R11 single pulse", !done0 && !err0, done0 | err0, 0);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1;
        @(negedge clk);
        sig = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 bypass", byp0 == 1, byp0, 1);
        chk("R1 out_en", oe0 == 0, oe0, 0);
        chk("R1 power off", pwr0 == 0, pwr0, 0);
        chk("R1 busy", busy0 == 0 && done0 == 0 && err0 == 0, busy0, 0);
        chk("R4 low-active power off at reset", pwr1 == 1, pwr1, 1);
    endtask

    task automatic t_enable();
        int i = 0, t_pwr = -1, t_byp = -1, t_oe = -1;
        bit bad_order = 0;
        bit gd, ge;
        int n;
        @(negedge clk);
        en0 = 1;
        @(negedge clk);
        en0 = 0;
        while (!done0 && !err0 && i < 2000) begin
            if (pwr0 && t_pwr < 0) t_pwr = i;
            if (!byp0 && t_byp < 0) t_byp = i;
            if (oe0 && t_oe < 0) t_oe = i;
            if (!byp0 && !lock0) bad_order = 1;
            if (i == 3) dis0 = 1;   // R10: request while busy
            if (i == 4) dis0 = 0;
            @(negedge clk);
            i++;
        end
        if (oe0 && t_oe < 0) t_oe = i;
        wait_end0(gd, ge, n);
        chk("R2 done", gd && !ge, gd, 1);
        chk("R2 power before bypass release", t_pwr >= 0 && t_pwr < t_byp, t_pwr, t_byp - 1);
        chk("R2 gate one cycle after bypass release", t_oe == t_byp + 1, t_oe, t_byp + 1);
        chk("R2 bypass clear only with lock", !bad_order, bad_order, 0);
        chk("R10 disable ignored while busy", oe0 == 1 && pwr0 == 1 && byp0 == 0, oe0, 1);
    endtask

    task automatic t_reprog(input logic [6:0] d, input logic [29:0] nm, input bit exp_ok,
                            input bit exp_byp, input bit check_order);
        int i = 0, t_b = -1, t_d = -1, t_n = -1, t_dn = -1;
        logic [6:0] pd = div0;
        logic [29:0] pn = num0, pdn = den0;
        bit gd, ge;
        int n;
        @(negedge clk);
        rdiv0 = d; rnum0 = nm; rp0 = 1;
        @(negedge clk);
        rp0 = 0;
        while (!done0 && !err0 && i < 2000) begin
            if (byp0 && t_b < 0) t_b = i;
            if (div0 != pd && t_d < 0) t_d = i;
            if (num0 != pn && t_n < 0) t_n = i;
            if (den0 != pdn && t_dn < 0) t_dn = i;
            @(negedge clk);
            i++;
        end
        wait_end0(gd, ge, n);
        if (check_order) begin
            chk("R6 bypass first", t_b == 0, t_b, 0);
            chk("R6 div then num then den", t_d == 1 && t_n == 2 && t_dn == 3, t_d*100 + t_n*10 + t_dn, 123);
        end
        chk("R6 den constant", den0 == 30'd1000000, den0, 1000000);
        chk("R6 fields written", div0 == d && num0 == nm, div0, d);
        chk(exp_ok ? "R8 relock done" : "R8 relock timeout error", gd == exp_ok && ge == !exp_ok, gd, exp_ok);
        chk("R8 bypass after relock attempt", byp0 == exp_byp, byp0, exp_byp);
    endtask

    task automatic t_reprog_bad(input logic [6:0] d);
        logic [6:0] pd = div0;
        logic [29:0] pn = num0;
        logic pb = byp0, pp = pwr0, po = oe0;
        bit seen_busy = 0;
        @(negedge clk);
        rdiv0 = d; rnum0 = 30'd99; rp0 = 1;
        @(negedge clk);
        rp0 = 0;
        chk("R9 error pulse", err0 == 1 && done0 == 0, err0, 1);
        for (int k = 0; k < 6; k++) begin
            if (busy0) seen_busy = 1;
            @(negedge clk);
        end
        chk("R9 no busy", !seen_busy, seen_busy, 0);
        chk("R9 no change", div0 == pd && num0 == pn && byp0 == pb && pwr0 == pp && oe0 == po, div0, pd);
    endtask

    task automatic t_disable();
        int i = 0;
        bit prev_byp = byp0;
        bit viol = 0;
        bit gd, ge;
        int n;
        @(negedge clk);
        dis0 = 1;
        @(negedge clk);
        dis0 = 0;
        chk("R5 bypass and gate first", byp0 == 1 && oe0 == 0 && pwr0 == 1, pwr0, 1);
        while (!done0 && !err0 && i < 50) begin
            if (!pwr0 && !prev_byp) viol = 1;
            prev_byp = byp0;
            @(negedge clk);
            i++;
        end
        wait_end0(gd, ge, n);
        chk("R5 done", gd, gd, 1);
        chk("R5 power removed in bypass", pwr0 == 0 && byp0 == 1 && !viol, pwr0, 0);
    endtask

    task automatic t_reprog_down();
        bit gd, ge;
        int n;
        @(negedge clk);
        rdiv0 = 7'd35; rnum0 = 30'd4242; rp0 = 1;
        @(negedge clk);
        rp0 = 0;
        wait_end0(gd, ge, n);
        chk("R7 done without wait", gd && !ge && n <= 4, n, 3);
        chk("R7 bypass stays set", byp0 == 1 && div0 == 7'd35, byp0, 1);
    endtask

    task automatic t_enable_timeout();
        logic pp = pwr0, pb = byp0, po = oe0;
        bit gd, ge;
        int n;
        dly0 = 1000;
        pulse(en0);
        chk("R3 busy during wait", busy0 == 1, busy0, 1);
        wait_end0(gd, ge, n);
        chk("R3 timeout error", ge && !gd, ge, 1);
        chk("R3 rollback", pwr0 == pp && byp0 == pb && oe0 == po, {pwr0, byp0, oe0}, {pp, pb, po});
        dly0 = 20;
    endtask

    task automatic t_polarity();
        int i = 0;
        pulse(en1);
        while (!done1 && !err1 && i < 2000) begin
            @(negedge clk);
            i++;
        end
        @(negedge clk);
        chk("R4 low-active power on", pwr1 == 0 && oe1 == 1 && byp1 == 0, pwr1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_enable();
        t_reprog(7'd40, 30'd123456, 1'b1, 1'b0, 1'b1);
        t_reprog_bad(7'd26);
        t_reprog_bad(7'd55);
        dly0 = 1000;
        t_reprog(7'd30, 30'd5000, 1'b0, 1'b1, 1'b0);
        dly0 = 20;
        t_reprog(7'd50, 30'd777, 1'b1, 1'b1, 1'b0);
        t_disable();
        t_reprog_down();
        t_enable_timeout();
        t_polarity();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule